// File: doc/BRIEF.md
# Burst-Capable Serial Word Receiver

This block is the receive data path of a low-level serial link endpoint working as the receiving end. A line decoder upstream presents one recovered bit per bit time as a single-cycle valid strobe with its value. The block finds a frame header made of a start (sync) bit and a word-kind bit. It then shifts in 32-bit data words, each optionally followed by a parity bit, and moves every complete word into an output holding latch. The host reads that latch through a shared 32-bit tri-state bus using two active-low strobes, one for each 16-bit half.

In single-word operation one word follows each header. In burst operation a single header is followed by words back to back, with no extra framing between them. A word is taken at every 32-bit boundary, or every 33-bit boundary when parity is on, until the line goes quiet. Flags tell the host that a word is waiting, that an unread word was overwritten, and that a received parity bit was wrong.

Top module: `burst_word_rx`

## Requirements
- R1: After reset `word_rdy`, `ovf` and `par_err` are 0.
- R2: While idle, received 0 bits are ignored and a 1 bit is taken as the sync bit. The next bit is the word-kind bit. A value of 0 means data words follow. A value of 1 makes the block ignore every bit up to the next gap, and no word is latched.
- R3: A data word is 32 bits sent most significant bit first. The first data bit received lands in bit 31 of the latch.
- R4: With `par_en`=1, a parity bit follows each 32 data bits. The total count of ones over the data bits and the parity bit must be odd when `par_odd`=1, or even when `par_odd`=0. A mismatch sets `par_err`, and the word is still latched. With `par_en`=0 no parity bit is expected.
- R5: With `burst_en`=1, words are captured every 32 bits (33 with parity) after one header, until a gap occurs. With `burst_en`=0, one word is captured per header and later bits are ignored until a gap.
- R6: A gap is a period of GAP_BITS*BIT_CYC clock cycles (16 by default) with no `bit_vld`. A gap ends the reception and returns the block to idle. A partly received word at the gap is discarded.
- R7: While `rd_lo_n` is 0, latch bits 15:0 are driven on `data_io[15:0]`. While `rd_hi_n` is 0, latch bits 31:16 are driven on `data_io[31:16]`. Otherwise each half is high impedance. The bus is driven only when `sink_mode`=1.
- R8: A read completes on the clock edge that samples `rd_hi_n` back at 1 after it was 0. The lower strobe alone completes nothing.
- R9: `word_rdy` rises in the cycle after the final bit of a word is sampled, and falls when a read completes.
- R10: If a word is latched while `word_rdy` is 1 and no read completes in that cycle, the new word overwrites the latch and `ovf` is set. `ovf` and `par_err` are sticky and clear when a read completes. A flag set in the same cycle as a completing read is kept.
- R11: With `sink_mode`=0, received bits are ignored and no word is latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sink_mode | input | 1 | 1 = receiving role, data words accepted |
| burst_en | input | 1 | 1 = burst reception |
| par_en | input | 1 | 1 = parity bit follows each word |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| bit_vld | input | 1 | One-cycle strobe: a recovered line bit is present |
| bit_val | input | 1 | Value of the recovered bit |
| rd_lo_n | input | 1 | Active-low strobe, drives latch bits 15:0 |
| rd_hi_n | input | 1 | Active-low strobe, drives latch bits 31:16; its release completes a read |
| data_io | inout | 32 | Tri-state host data bus |
| word_rdy | output | 1 | A latched word is waiting to be read |
| ovf | output | 1 | An unread word was overwritten |
| par_err | output | 1 | A parity mismatch was seen since the last completed read |

## Verification
The assertions assume that `bit_vld` pulses last one cycle and are spaced well below the gap length inside a frame. They also assume that the mode inputs stay stable for the whole reception and that `rd_hi_n` is held at 1 through reset. The bench keeps within these limits by setting the mode inputs only between frames, separated by gaps. It sends each bit as a one-cycle strobe followed by idle cycles, and it runs its strobe sequences only in quiet windows shorter than a gap. Random words and random parity settings are mixed with directed cases for overflow, partial words, the ignored word kind and the non-receiving role.

// File: rtl/burst_word_rx_pkg.sv
package burst_word_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_KIND = 2'd1,
    RX_DATA = 2'd2,
    RX_SKIP = 2'd3
  } rx_state_e;

endpackage

// File: rtl/rx_gap_timer.sv
module rx_gap_timer #(
  parameter int BIT_CYC  = 4,
  parameter int GAP_BITS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  output logic gap
);

  localparam int GAP_CYC = BIT_CYC * GAP_BITS;
  localparam int CW      = $clog2(GAP_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    gap   = 1'b0;
    if (bit_vld) begin
      cnt_n = '0;
    end else if (cnt_q != CW'(GAP_CYC)) begin
      cnt_n = cnt_q + 1'b1;
      if (cnt_q == CW'(GAP_CYC - 1)) gap = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CW'(GAP_CYC);
    else        cnt_q <= cnt_n;
  end

endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
  import burst_word_rx_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sink_mode,
  input  logic              burst_en,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              bit_vld,
  input  logic              bit_val,
  input  logic              gap,
  output logic              word_stb,
  output logic [WORD_W-1:0] word_d,
  output logic              par_bad,
  output logic              rx_idle
);

  localparam int CNT_W = $clog2(WORD_W + 2);

  rx_state_e         st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [WORD_W-1:0] sh_q, sh_n;
  logic              pacc_q, pacc_n;
  logic [CNT_W-1:0]  last_idx;
  logic              data_bit;

  assign last_idx = par_en ? CNT_W'(WORD_W) : CNT_W'(WORD_W - 1);
  assign data_bit = (cnt_q < CNT_W'(WORD_W));
  assign rx_idle  = (st_q == RX_IDLE);

  always_comb begin
    st_n     = st_q;
    cnt_n    = cnt_q;
    sh_n     = sh_q;
    pacc_n   = pacc_q;
    word_stb = 1'b0;
    word_d   = par_en ? sh_q : {sh_q[WORD_W-2:0], bit_val};
    par_bad  = par_en & ((pacc_q ^ bit_val) != par_odd);
    if (!sink_mode) begin
      st_n = RX_IDLE;
    end else begin
      unique case (st_q)
        RX_IDLE: begin
          if (bit_vld && bit_val) st_n = RX_KIND;
        end
        RX_KIND: begin
          if (gap) begin
            st_n = RX_IDLE;
          end else if (bit_vld) begin
            cnt_n  = '0;
            pacc_n = 1'b0;
            st_n   = bit_val ? RX_SKIP : RX_DATA;
          end
        end
        RX_DATA: begin
          if (gap) begin
            st_n = RX_IDLE;
          end else if (bit_vld) begin
            if (data_bit) begin
              sh_n   = {sh_q[WORD_W-2:0], bit_val};
              pacc_n = pacc_q ^ bit_val;
            end
            if (cnt_q == last_idx) begin
              word_stb = 1'b1;
              cnt_n    = '0;
              pacc_n   = 1'b0;
              if (!burst_en) st_n = RX_SKIP;
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        RX_SKIP: begin
          if (gap) st_n = RX_IDLE;
        end
        default: st_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      pacc_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      pacc_q <= pacc_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sh_q <= '0;
    else if (bit_vld && data_bit) sh_q <= sh_n;
  end

endmodule

// File: rtl/rx_out_latch.sv
module rx_out_latch #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sink_mode,
  input  logic              word_stb,
  input  logic [WORD_W-1:0] word_d,
  input  logic              par_bad,
  input  logic              rd_hi_n,
  output logic [WORD_W-1:0] lat_q,
  output logic              rd_done,
  output logic              word_rdy,
  output logic              ovf,
  output logic              par_err
);

  logic rd_hi_q;
  logic rdy_n, ovf_n, perr_n;

  assign rd_done = sink_mode & rd_hi_n & ~rd_hi_q;

  always_comb begin
    rdy_n  = word_stb | (word_rdy & ~rd_done);
    ovf_n  = (ovf & ~rd_done) | (word_stb & word_rdy & ~rd_done);
    perr_n = (par_err & ~rd_done) | (word_stb & par_bad);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hi_q  <= 1'b1;
      word_rdy <= 1'b0;
      ovf      <= 1'b0;
      par_err  <= 1'b0;
    end else begin
      rd_hi_q  <= rd_hi_n;
      word_rdy <= rdy_n;
      ovf      <= ovf_n;
      par_err  <= perr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lat_q <= '0;
    else if (word_stb) lat_q <= word_d;
  end

endmodule

// File: rtl/burst_word_rx.sv
module burst_word_rx #(
  parameter int WORD_W   = 32,
  parameter int BIT_CYC  = 4,
  parameter int GAP_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sink_mode,
  input  logic              burst_en,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              bit_vld,
  input  logic              bit_val,
  input  logic              rd_lo_n,
  input  logic              rd_hi_n,
  inout  wire  [WORD_W-1:0] data_io,
  output logic              word_rdy,
  output logic              ovf,
  output logic              par_err
);

  localparam int HALF = WORD_W / 2;

  logic              rst_s1_q, rst_sync_n;
  logic              gap_w;
  logic              word_stb_w;
  logic [WORD_W-1:0] word_d_w;
  logic              par_bad_w;
  logic              rx_idle_w;
  logic [WORD_W-1:0] lat_w;
  logic              rd_done_w;
  logic              oe_lo, oe_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  rx_gap_timer #(.BIT_CYC(BIT_CYC), .GAP_BITS(GAP_BITS)) gap_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .bit_vld (bit_vld),
    .gap     (gap_w)
  );

  rx_deframer #(.WORD_W(WORD_W)) dfr_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sink_mode (sink_mode),
    .burst_en  (burst_en),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .bit_vld   (bit_vld),
    .bit_val   (bit_val),
    .gap       (gap_w),
    .word_stb  (word_stb_w),
    .word_d    (word_d_w),
    .par_bad   (par_bad_w),
    .rx_idle   (rx_idle_w)
  );

  rx_out_latch #(.WORD_W(WORD_W)) lat_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sink_mode (sink_mode),
    .word_stb  (word_stb_w),
    .word_d    (word_d_w),
    .par_bad   (par_bad_w),
    .rd_hi_n   (rd_hi_n),
    .lat_q     (lat_w),
    .rd_done   (rd_done_w),
    .word_rdy  (word_rdy),
    .ovf       (ovf),
    .par_err   (par_err)
  );

  assign oe_lo = sink_mode & ~rd_lo_n;
  assign oe_hi = sink_mode & ~rd_hi_n;

  assign data_io[HALF-1:0]      = oe_lo ? lat_w[HALF-1:0]      : {HALF{1'bz}};
  assign data_io[WORD_W-1:HALF] = oe_hi ? lat_w[WORD_W-1:HALF] : {(WORD_W-HALF){1'bz}};

endmodule

// File: rtl/burst_word_rx_chk.sv
module burst_word_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic sink_mode,
  input logic rd_hi_n,
  input logic word_stb,
  input logic par_bad,
  input logic gap,
  input logic rx_idle,
  input logic word_rdy,
  input logic ovf,
  input logic par_err
);

  // R9: a latched word raises word_rdy
  a_r9_rdy_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |=> word_rdy);

  // R8/R9: completed read without a new word drops word_rdy
  a_r8_read_clears_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    (sink_mode && $rose(rd_hi_n) && !word_stb) |=> !word_rdy);

  // R10: overwrite of an unread word raises ovf
  a_r10_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && word_rdy && !(sink_mode && $rose(rd_hi_n))) |=> ovf);

  // R10: ovf cannot rise without a word arriving
  a_r10_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_stb) |=> !$rose(ovf));

  // R4: bad parity flags par_err
  a_r4_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && par_bad) |=> par_err);

  // R6: a gap returns the receiver to idle
  a_r6_gap_idle: assert property (@(posedge clk) disable iff (!rst_n)
    gap |=> rx_idle);

  // R11: no word is produced outside the receiving role
  a_r11_sink_only: assert property (@(posedge clk) disable iff (!rst_n)
    !sink_mode |-> !word_stb);

endmodule

bind burst_word_rx burst_word_rx_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .sink_mode (sink_mode),
  .rd_hi_n   (rd_hi_n),
  .word_stb  (word_stb_w),
  .par_bad   (par_bad_w),
  .gap       (gap_w),
  .rx_idle   (rx_idle_w),
  .word_rdy  (word_rdy),
  .ovf       (ovf),
  .par_err   (par_err)
);

// File: tb/burst_word_rx_tb_top.sv
`timescale 1ns/1ps
module burst_word_rx_tb_top;

  localparam int BIT_CYC = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic sink_mode, burst_en, par_en, par_odd;
  logic bit_vld, bit_val, rd_lo_n, rd_hi_n;
  wire  [31:0] data_io;
  logic word_rdy, ovf, par_err;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  burst_word_rx dut_i (
    .clk(clk), .rst_n(rst_n), .sink_mode(sink_mode), .burst_en(burst_en),
    .par_en(par_en), .par_odd(par_odd), .bit_vld(bit_vld), .bit_val(bit_val),
    .rd_lo_n(rd_lo_n), .rd_hi_n(rd_hi_n), .data_io(data_io),
    .word_rdy(word_rdy), .ovf(ovf), .par_err(par_err)
  );

  function automatic logic par_of(input logic [31:0] w, input logic odd);
    return (^w) ^ odd;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic v);
    @(negedge clk);
    bit_vld = 1'b1; bit_val = v;
    @(negedge clk);
    bit_vld = 1'b0; bit_val = 1'b0;
    repeat (BIT_CYC - 2) @(negedge clk);
  endtask

  task automatic send_gap();
    repeat (24) @(negedge clk);
  endtask

  task automatic send_header(input logic kind);
    send_bit(1'b1);
    send_bit(kind);
  endtask

  task automatic send_word(input logic [31:0] w, input logic bad_par);
    for (int i = 31; i >= 0; i--) send_bit(w[i]);
    if (par_en) send_bit(par_of(w, par_odd) ^ bad_par);
  endtask

  task automatic read_word(output logic [31:0] w);
    @(negedge clk);
    rd_lo_n = 1'b0;
    @(negedge clk);
    w[15:0] = data_io[15:0];
    rd_lo_n = 1'b1; rd_hi_n = 1'b0;
    @(negedge clk);
    w[31:16] = data_io[31:16];
    rd_hi_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic single_word(input logic [31:0] w, input logic bad);
    send_header(1'b0);
    send_word(w, bad);
    send_gap();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rw, w0, w1, w2;
    void'($urandom(32'h5EED_0421));
    rst_n = 1'b0; sink_mode = 1'b1; burst_en = 1'b0; par_en = 1'b0; par_odd = 1'b0;
    bit_vld = 1'b0; bit_val = 1'b0; rd_lo_n = 1'b1; rd_hi_n = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check(!word_rdy && !ovf && !par_err, "R1", {29'd0, word_rdy, ovf, par_err}, 32'd0);

    // R2/R3 leading zeros ignored, MSB first
    send_bit(1'b0); send_bit(1'b0);
    w0 = 32'h8000_0001;
    single_word(w0, 1'b0);
    check(word_rdy, "R9", {31'd0, word_rdy}, 32'd1);
    read_word(rw);
    check(rw == w0, "R3", rw, w0);
    check(!word_rdy, "R8", {31'd0, word_rdy}, 32'd0);

    // R8 lower strobe alone leaves word_rdy set
    w0 = 32'hA5A5_1234;
    single_word(w0, 1'b0);
    @(negedge clk); rd_lo_n = 1'b0;
    @(negedge clk);
    check(data_io[15:0] == w0[15:0], "R7", {16'd0, data_io[15:0]}, {16'd0, w0[15:0]});
    rd_lo_n = 1'b1;
    repeat (2) @(negedge clk);
    check(word_rdy, "R8", {31'd0, word_rdy}, 32'd1);
    read_word(rw);
    check(rw == w0, "R7", rw, w0);

    // R4 good parity odd and even, then bad parity
    par_en = 1'b1;
    for (int k = 0; k < 2; k++) begin
      par_odd = k[0];
      w0 = $urandom;
      single_word(w0, 1'b0);
      read_word(rw);
      check(rw == w0 && !par_err, "R4", rw, w0);
    end
    par_odd = 1'b1;
    w0 = $urandom;
    single_word(w0, 1'b1);
    check(par_err && word_rdy, "R4", {30'd0, par_err, word_rdy}, 32'd3);
    read_word(rw);
    check(rw == w0, "R4", rw, w0);
    check(!par_err, "R10", {31'd0, par_err}, 32'd0);

    // R10 overflow in burst: two words unread
    burst_en = 1'b1;
    w0 = $urandom; w1 = $urandom;
    send_header(1'b0);
    send_word(w0, 1'b0);
    send_word(w1, 1'b0);
    send_gap();
    check(ovf && word_rdy, "R10", {30'd0, ovf, word_rdy}, 32'd3);
    read_word(rw);
    check(rw == w1, "R10", rw, w1);
    check(!ovf && !word_rdy, "R10", {30'd0, ovf, word_rdy}, 32'd0);

    // R5 burst of three words read between words, parity off
    par_en = 1'b0;
    w0 = $urandom; w1 = $urandom; w2 = $urandom;
    send_header(1'b0);
    send_word(w0, 1'b0); read_word(rw);
    check(rw == w0, "R5", rw, w0);
    send_word(w1, 1'b0); read_word(rw);
    check(rw == w1, "R5", rw, w1);
    send_word(w2, 1'b0); read_word(rw);
    check(rw == w2 && !ovf, "R5", rw, w2);
    send_gap();

    // R5 single mode: bits after the word ignored until gap
    burst_en = 1'b0;
    w0 = $urandom; w1 = $urandom;
    send_header(1'b0);
    send_word(w0, 1'b0);
    send_word(w1, 1'b0);
    send_gap();
    check(!ovf, "R5", {31'd0, ovf}, 32'd0);
    read_word(rw);
    check(rw == w0, "R5", rw, w0);

    // R6 partial word discarded at gap, then next word intact
    send_header(1'b0);
    for (int i = 0; i < 20; i++) send_bit(1'b1);
    send_gap();
    check(!word_rdy, "R6", {31'd0, word_rdy}, 32'd0);
    w0 = 32'h0F0F_F0F0;
    single_word(w0, 1'b0);
    read_word(rw);
    check(rw == w0, "R6", rw, w0);

    // R2 word-kind 1 frame ignored
    send_header(1'b1);
    send_word($urandom, 1'b0);
    send_gap();
    check(!word_rdy, "R2", {31'd0, word_rdy}, 32'd0);

    // R11 not receiving role
    sink_mode = 1'b0;
    single_word($urandom, 1'b0);
    check(!word_rdy && !ovf, "R11", {30'd0, word_rdy, ovf}, 32'd0);
    sink_mode = 1'b1;

    // random single words with random parity settings
    for (int n = 0; n < 24; n++) begin
      logic bad;
      par_en  = $urandom_range(0, 1);
      par_odd = $urandom_range(0, 1);
      bad     = par_en & ($urandom_range(0, 3) == 0);
      w0 = $urandom;
      single_word(w0, bad);
      check(par_err == bad, "R4", {31'd0, par_err}, {31'd0, bad});
      read_word(rw);
      check(rw == w0, "R3", rw, w0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule